// File: doc/BRIEF.md
# Shared Counter with Per-Processor Compare Timers

This block holds one 32-bit time base that every processor in a cluster sees, plus a small bank of local registers for each processor: a compare value, a local pending word, a local mask, a compare route and an alias selector. When the shared count equals a processor's compare value, that processor's compare-pending bit is set. The compare interrupt is then driven onto one of that processor's interrupt pins, provided three conditions hold: the interrupt is unmasked, its route is enabled, and the route names a legal pin.

Software reaches the block through a simple register port. Each request carries the index of the processor that issues it. Every processor addresses its own local bank through the local window. Through the alias window it reaches whichever bank its alias selector names. The counter runs from reset. A halt bit in the configuration word stops it, and only while it is halted can software load a new count.

The counter is controlled by a two-state machine:
- ST_RUN: the count advances by one each clock. A configuration write with the halt bit at 1 takes the transition RUN_TO_HALT.
- ST_HALT: the count holds, and a counter-low write loads it. A configuration write with the halt bit at 0 takes the transition HALT_TO_RUN.
- Any other configuration write leaves the state unchanged.

Top module: `shared_cmp_timer`

## Requirements
- R1: Writing bit 0 of the configuration word (address 0x00) with 1 moves the counter from ST_RUN to ST_HALT, and writing it with 0 moves it back. A write of the value already in force changes nothing. While halted, the count holds. Reading 0x00 returns the halt state in bit 0.
- R2: In ST_RUN, the count increases by exactly one every clock.
- R3: A write to counter-low (0x01) loads the count only in ST_HALT. In ST_RUN the write is ignored.
- R4: Counter-high (0x02), user counter-high (0x04) and compare-high (local offset 8) read as zero. User counter-low (0x03) reads the count. Writes to 0x03 and 0x04 change nothing.
- R5: A compare write (local offset 7) clears that processor's compare-pending bit, which drops its pin, and stores the new 32-bit compare value.
- R6: While the counter runs, a count equal to a processor's compare value sets its compare-pending bit (bit 1 of the pending word at offset 1). The bit stays set until the next compare write.
- R7: Processor c's pin p (cpu_irq[c*NPIN+p]) is high exactly when all of the following hold: pending bit 1 is set, mask bit 1 is set, the route flag (bit 31) is set, and the route pin field equals p.
- R8: The 6-bit local mask (read at offset 2) changes only through two writes. A set-mask write (offset 3) sets the bits written as 1. A clear-mask write (offset 4) clears the bits written as 1.
- R9: A compare-route write (offset 5) whose pin field, bits [5:0], exceeds NPIN-1 is rejected. An accepted write keeps bit 31 and the pin field, and clears every other bit.
- R10: An alias-selector write (offset 6) of NCPU or more is rejected. Accesses at 0x20+offset reach the local bank of the processor the issuer's selector names.
- R11: After reset: the count is 0 and running, every compare value is 0xFFFFFFFF, every pending word is 0, every mask is 0x32, every route is 0x80000000, and every selector is 0.
- R12: The identity register (offset 0) returns the index of the bank that is accessed. That is the issuer in the local window (0x10+offset), and the selected processor in the alias window.
- R13: A read request is answered one clock later, with rsp_valid high for one cycle. A write gives no response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Register request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_cpu | input | CPU_W | Index of the issuing processor |
| req_addr | input | 6 | Word address: [5:4] section, [3:0] offset |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid |
| rsp_data | output | 32 | Read data |
| cpu_irq | output | NCPU*NPIN | Compare interrupt pins, NPIN per processor |

## Verification
The bench builds the block with three processors and six pins per processor. With three processors, the selector width of two bits can encode the illegal value 3, so the rejected alias write becomes reachable. Three processors also give an alias target that is neither the issuer nor processor 0. Six pins let a route to pin 6 fit in the field and be refused, while pin 3 lands in the middle of the output vector. Most table rows run with the counter halted, so every read value can be predicted exactly. The match test loads the count just below the compare value and then releases the counter.

// File: rtl/sct_pkg.sv
package sct_pkg;

    typedef enum logic {
        ST_RUN  = 1'b0,
        ST_HALT = 1'b1
    } cnt_state_e;

    // address sections, taken from req_addr[5:4]
    localparam logic [1:0] SEC_SHARED = 2'd0;
    localparam logic [1:0] SEC_LOCAL  = 2'd1;
    localparam logic [1:0] SEC_ALIAS  = 2'd2;

    // shared words
    localparam logic [5:0] ADR_CFG    = 6'h00;
    localparam logic [5:0] ADR_CNT_LO = 6'h01;
    localparam logic [5:0] ADR_CNT_HI = 6'h02;
    localparam logic [5:0] ADR_UCN_LO = 6'h03;
    localparam logic [5:0] ADR_UCN_HI = 6'h04;

    // local bank offsets
    localparam logic [3:0] OFF_IDENT = 4'd0;
    localparam logic [3:0] OFF_PEND  = 4'd1;
    localparam logic [3:0] OFF_MASK  = 4'd2;
    localparam logic [3:0] OFF_MSET  = 4'd3;
    localparam logic [3:0] OFF_MCLR  = 4'd4;
    localparam logic [3:0] OFF_ROUTE = 4'd5;
    localparam logic [3:0] OFF_SEL   = 4'd6;
    localparam logic [3:0] OFF_CMPLO = 4'd7;
    localparam logic [3:0] OFF_CMPHI = 4'd8;

    localparam int          LW        = 6;     // local pending / mask width
    localparam int          CMP_BIT   = 1;     // compare source position
    localparam logic [5:0]  MASK_RST  = 6'h32;
    localparam int          ROUTE_FW  = 6;     // route pin field width
    localparam int          FLAG_BIT  = 31;    // route-enable flag

endpackage

// File: rtl/sct_count_fsm.sv
module sct_count_fsm
    import sct_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_wr_i,
    input  logic             cfg_halt_i,
    input  logic             load_wr_i,
    input  logic [CNT_W-1:0] load_val_i,
    output logic [CNT_W-1:0] count_o,
    output logic             running_o
);

    cnt_state_e       state_q, state_d;
    logic [CNT_W-1:0] count_q;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_RUN;
        else        state_q <= state_d;
    end

    // next state: RUN_TO_HALT and HALT_TO_RUN
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN:  if (cfg_wr_i && cfg_halt_i)  state_d = ST_HALT;
            ST_HALT: if (cfg_wr_i && !cfg_halt_i) state_d = ST_RUN;
            default: state_d = ST_RUN;
        endcase
    end

    // outputs: count advances in ST_RUN, accepts loads in ST_HALT
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q <= '0;
        end else begin
            unique case (state_q)
                ST_RUN:  count_q <= count_q + CNT_W'(1);
                ST_HALT: if (load_wr_i) count_q <= load_val_i;
                default: count_q <= count_q;
            endcase
        end
    end

    assign count_o   = count_q;
    assign running_o = (state_q == ST_RUN);

    // R1: halted counter holds unless loaded
    a_r1_halt_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HALT && !load_wr_i) |=> $stable(count_q));

    // R2: running counter steps by one
    a_r2_run_steps: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN) |=> (count_q == $past(count_q) + CNT_W'(1)));

endmodule

// File: rtl/sct_cpu_bank.sv
module sct_cpu_bank
    import sct_pkg::*;
#(
    parameter int NCPU  = 2,
    parameter int NPIN  = 6,
    parameter int CNT_W = 32,
    localparam int CPU_W = (NCPU > 1) ? $clog2(NCPU) : 1,
    localparam int PIN_W = (NPIN > 1) ? $clog2(NPIN) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sel_i,
    input  logic             wr_i,
    input  logic [3:0]       off_i,
    input  logic [31:0]      wdata_i,
    input  logic [CNT_W-1:0] count_i,
    input  logic             running_i,
    output logic [LW-1:0]    pend_o,
    output logic [LW-1:0]    mask_o,
    output logic [31:0]      route_o,
    output logic [CNT_W-1:0] cmp_o,
    output logic [CPU_W-1:0] other_o,
    output logic [NPIN-1:0]  pins_o
);

    logic             cpend_q;
    logic [LW-1:0]    mask_q;
    logic             flag_q;
    logic [PIN_W-1:0] pin_q;
    logic [CNT_W-1:0] cmp_q;
    logic [CPU_W-1:0] other_q;

    logic wr_here, cmp_wr, set_wr, clr_wr, route_wr, sel_wr;
    logic route_ok, sel_ok, match;

    assign wr_here  = sel_i && wr_i;
    assign cmp_wr   = wr_here && (off_i == OFF_CMPLO);
    assign set_wr   = wr_here && (off_i == OFF_MSET);
    assign clr_wr   = wr_here && (off_i == OFF_MCLR);
    assign route_wr = wr_here && (off_i == OFF_ROUTE);
    assign sel_wr   = wr_here && (off_i == OFF_SEL);

    assign route_ok = (int'(wdata_i[ROUTE_FW-1:0]) <= NPIN - 1);
    assign sel_ok   = (wdata_i < 32'(NCPU));
    assign match    = running_i && (count_i == cmp_q);

    // compare value and pending bit; a compare write wins over a match
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmp_q   <= '1;
            cpend_q <= 1'b0;
        end else if (cmp_wr) begin
            cmp_q   <= wdata_i[CNT_W-1:0];
            cpend_q <= 1'b0;
        end else if (match) begin
            cpend_q <= 1'b1;
        end
    end

    // mask through set / clear strobes only
    always_ff @(posedge clk) begin
        if (!rst_n)      mask_q <= MASK_RST;
        else if (set_wr) mask_q <= mask_q | wdata_i[LW-1:0];
        else if (clr_wr) mask_q <= mask_q & ~wdata_i[LW-1:0];
    end

    // compare route and alias selector, with range checks
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_q  <= 1'b1;
            pin_q   <= '0;
            other_q <= '0;
        end else begin
            if (route_wr && route_ok) begin
                flag_q <= wdata_i[FLAG_BIT];
                pin_q  <= wdata_i[PIN_W-1:0];
            end
            if (sel_wr && sel_ok) other_q <= wdata_i[CPU_W-1:0];
        end
    end

    always_comb begin
        pend_o          = '0;
        pend_o[CMP_BIT] = cpend_q;
    end

    always_comb begin
        route_o                 = '0;
        route_o[FLAG_BIT]       = flag_q;
        route_o[PIN_W-1:0]      = pin_q;
    end

    assign mask_o  = mask_q;
    assign cmp_o   = cmp_q;
    assign other_o = other_q;

    for (genvar p = 0; p < NPIN; p++) begin : g_pin
        assign pins_o[p] = cpend_q && mask_q[CMP_BIT] && flag_q
                           && (int'(pin_q) == p);
    end

    // R5: a compare write clears pending and stores the value
    a_r5_cmp_clears: assert property (@(posedge clk) disable iff (!rst_n)
        cmp_wr |=> (!cpend_q && cmp_q == $past(wdata_i[CNT_W-1:0])));

    // R6: a match while running sets pending
    a_r6_match_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (running_i && count_i == cmp_q && !cmp_wr) |=> cpend_q);

    // R7: at most one pin, and only with pending, unmasked and routed
    a_r7_pin_gated: assert property (@(posedge clk) disable iff (!rst_n)
        (pins_o != '0) |-> (cpend_q && mask_q[CMP_BIT] && flag_q && $onehot0(pins_o)));

    // R8: mask moves only on set / clear writes
    a_r8_mask_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !(set_wr || clr_wr) |=> $stable(mask_q));

    // R10: selector never names a missing processor
    a_r10_sel_range: assert property (@(posedge clk) disable iff (!rst_n)
        int'(other_q) < NCPU);

endmodule

// File: rtl/shared_cmp_timer.sv
module shared_cmp_timer
    import sct_pkg::*;
#(
    parameter int NCPU  = 2,
    parameter int NPIN  = 6,
    parameter int CNT_W = 32,
    localparam int CPU_W = (NCPU > 1) ? $clog2(NCPU) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_valid,
    input  logic                 req_write,
    input  logic [CPU_W-1:0]     req_cpu,
    input  logic [5:0]           req_addr,
    input  logic [31:0]          req_wdata,
    output logic                 rsp_valid,
    output logic [31:0]          rsp_data,
    output logic [NCPU*NPIN-1:0] cpu_irq
);

    logic [CNT_W-1:0] count;
    logic             running;

    logic [LW-1:0]    pend_a  [NCPU];
    logic [LW-1:0]    mask_a  [NCPU];
    logic [31:0]      route_a [NCPU];
    logic [CNT_W-1:0] cmp_a   [NCPU];
    logic [CPU_W-1:0] other_a [NCPU];
    logic [NPIN-1:0]  pins_a  [NCPU];

    logic             req_ok;
    logic [1:0]       sect;
    logic [3:0]       off;
    logic [CPU_W-1:0] issuer;
    logic [CPU_W-1:0] target;
    logic             bank_acc;
    logic [31:0]      rd_d;
    logic             rsp_valid_q;
    logic [31:0]      rsp_data_q;

    assign req_ok   = req_valid && (int'(req_cpu) < NCPU);
    assign sect     = req_addr[5:4];
    assign off      = req_addr[3:0];
    assign issuer   = req_ok ? req_cpu : '0;
    assign target   = (sect == SEC_ALIAS) ? other_a[issuer] : issuer;
    assign bank_acc = req_ok && (sect == SEC_LOCAL || sect == SEC_ALIAS);

    sct_count_fsm #(.CNT_W(CNT_W)) u_count (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_wr_i   (req_ok && req_write && req_addr == ADR_CFG),
        .cfg_halt_i (req_wdata[0]),
        .load_wr_i  (req_ok && req_write && req_addr == ADR_CNT_LO),
        .load_val_i (req_wdata[CNT_W-1:0]),
        .count_o    (count),
        .running_o  (running)
    );

    for (genvar c = 0; c < NCPU; c++) begin : g_cpu
        sct_cpu_bank #(.NCPU(NCPU), .NPIN(NPIN), .CNT_W(CNT_W)) u_bank (
            .clk       (clk),
            .rst_n     (rst_n),
            .sel_i     (bank_acc && int'(target) == c),
            .wr_i      (req_write),
            .off_i     (off),
            .wdata_i   (req_wdata),
            .count_i   (count),
            .running_i (running),
            .pend_o    (pend_a[c]),
            .mask_o    (mask_a[c]),
            .route_o   (route_a[c]),
            .cmp_o     (cmp_a[c]),
            .other_o   (other_a[c]),
            .pins_o    (pins_a[c])
        );
        assign cpu_irq[c*NPIN +: NPIN] = pins_a[c];
    end

    // read selection
    always_comb begin
        rd_d = '0;
        if (sect == SEC_SHARED) begin
            case (req_addr)
                ADR_CFG:    rd_d = {31'b0, !running};
                ADR_CNT_LO: rd_d = 32'(count);
                ADR_UCN_LO: rd_d = 32'(count);
                default:    rd_d = '0;
            endcase
        end else if (sect == SEC_LOCAL || sect == SEC_ALIAS) begin
            case (off)
                OFF_IDENT: rd_d = 32'(target);
                OFF_PEND:  rd_d = 32'(pend_a[target]);
                OFF_MASK:  rd_d = 32'(mask_a[target]);
                OFF_ROUTE: rd_d = route_a[target];
                OFF_SEL:   rd_d = 32'(other_a[target]);
                OFF_CMPLO: rd_d = 32'(cmp_a[target]);
                default:   rd_d = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid_q <= 1'b0;
            rsp_data_q  <= '0;
        end else begin
            rsp_valid_q <= req_ok && !req_write;
            if (req_ok && !req_write) rsp_data_q <= rd_d;
        end
    end

    assign rsp_valid = rsp_valid_q;
    assign rsp_data  = rsp_data_q;

    // R13: each accepted read is answered on the next clock
    a_r13_read_answered: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write && int'(req_cpu) < NCPU) |=> rsp_valid);

    // R13: writes never raise a response
    a_r13_write_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write) |=> !rsp_valid);

endmodule

// File: tb/shared_cmp_timer_tb_top.sv
module shared_cmp_timer_tb_top;

    localparam int NCPU = 3;
    localparam int NPIN = 6;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic                 req_valid = 1'b0;
    logic                 req_write = 1'b0;
    logic [1:0]           req_cpu = '0;
    logic [5:0]           req_addr = '0;
    logic [31:0]          req_wdata = '0;
    logic                 rsp_valid;
    logic [31:0]          rsp_data;
    logic [NCPU*NPIN-1:0] cpu_irq;

    int  total = 0;
    int  bad = 0;
    bit  done = 1'b0;

    always #5 clk = ~clk;

    shared_cmp_timer #(.NCPU(NCPU), .NPIN(NPIN), .CNT_W(32)) dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_cpu(req_cpu), .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_data(rsp_data), .cpu_irq(cpu_irq)
    );

    typedef struct packed {
        logic        wr;
        logic [1:0]  cpu;
        logic [5:0]  addr;
        logic [31:0] data;
        logic [31:0] exp;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 38;
    localparam vec_t TAB [NV] = '{
        '{1'b0, 2'd0, 6'h11, 32'h0,        32'h0,        4'd11}, // R11 pending
        '{1'b0, 2'd0, 6'h12, 32'h0,        32'h32,       4'd11}, // R11 mask
        '{1'b0, 2'd1, 6'h15, 32'h0,        32'h80000000, 4'd11}, // R11 route
        '{1'b0, 2'd0, 6'h17, 32'h0,        32'hFFFFFFFF, 4'd11}, // R11 compare
        '{1'b0, 2'd2, 6'h10, 32'h0,        32'h2,        4'd12}, // R12 ident
        '{1'b0, 2'd0, 6'h02, 32'h0,        32'h0,        4'd4},  // R4 cnt hi
        '{1'b0, 2'd0, 6'h18, 32'h0,        32'h0,        4'd4},  // R4 cmp hi
        '{1'b0, 2'd0, 6'h00, 32'h0,        32'h0,        4'd11}, // R11 running
        '{1'b1, 2'd0, 6'h00, 32'h1,        32'h0,        4'd1},  // R1 halt
        '{1'b0, 2'd0, 6'h00, 32'h0,        32'h1,        4'd1},
        '{1'b1, 2'd0, 6'h01, 32'h100,      32'h0,        4'd3},  // R3 load
        '{1'b0, 2'd0, 6'h01, 32'h0,        32'h100,      4'd3},
        '{1'b0, 2'd1, 6'h03, 32'h0,        32'h100,      4'd4},  // R4 mirror
        '{1'b1, 2'd0, 6'h03, 32'h5,        32'h0,        4'd4},
        '{1'b1, 2'd0, 6'h04, 32'h7,        32'h0,        4'd4},
        '{1'b0, 2'd0, 6'h01, 32'h0,        32'h100,      4'd4},
        '{1'b0, 2'd0, 6'h04, 32'h0,        32'h0,        4'd4},
        '{1'b1, 2'd0, 6'h14, 32'h2,        32'h0,        4'd8},  // R8 clear
        '{1'b0, 2'd0, 6'h12, 32'h0,        32'h30,       4'd8},
        '{1'b1, 2'd0, 6'h13, 32'hF,        32'h0,        4'd8},  // R8 set
        '{1'b0, 2'd0, 6'h12, 32'h0,        32'h3F,       4'd8},
        '{1'b1, 2'd0, 6'h15, 32'h80000006, 32'h0,        4'd9},  // R9 reject
        '{1'b0, 2'd0, 6'h15, 32'h0,        32'h80000000, 4'd9},
        '{1'b1, 2'd0, 6'h15, 32'hFFFFFF03, 32'h0,        4'd9},  // R9 accept
        '{1'b0, 2'd0, 6'h15, 32'h0,        32'h80000003, 4'd9},
        '{1'b1, 2'd0, 6'h16, 32'h3,        32'h0,        4'd10}, // R10 reject
        '{1'b0, 2'd0, 6'h16, 32'h0,        32'h0,        4'd10},
        '{1'b1, 2'd0, 6'h16, 32'h2,        32'h0,        4'd10}, // R10 accept
        '{1'b0, 2'd0, 6'h16, 32'h0,        32'h2,        4'd10},
        '{1'b0, 2'd0, 6'h20, 32'h0,        32'h2,        4'd12}, // R12 alias ident
        '{1'b1, 2'd0, 6'h27, 32'h55,       32'h0,        4'd10}, // R10 alias write
        '{1'b0, 2'd2, 6'h17, 32'h0,        32'h55,       4'd10},
        '{1'b0, 2'd0, 6'h17, 32'h0,        32'hFFFFFFFF, 4'd10},
        '{1'b0, 2'd0, 6'h27, 32'h0,        32'h55,       4'd10},
        '{1'b1, 2'd0, 6'h00, 32'h1,        32'h0,        4'd1},  // R1 same value
        '{1'b0, 2'd0, 6'h01, 32'h0,        32'h100,      4'd1},
        '{1'b0, 2'd1, 6'h10, 32'h0,        32'h1,        4'd12},
        '{1'b0, 2'd1, 6'h12, 32'h0,        32'h32,       4'd8}   // R8 other bank
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic acc(input logic wr, input logic [1:0] cpu, input logic [5:0] addr,
                       input logic [31:0] d, output logic [31:0] rd);
        req_valid = 1'b1; req_write = wr; req_cpu = cpu; req_addr = addr; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
        rd = rsp_data;
    endtask

    initial begin
        repeat (2000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] rd, a, b;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        check("R11 irq after reset", 32'(cpu_irq), 32'h0);

        for (int i = 0; i < NV; i++) begin
            acc(TAB[i].wr, TAB[i].cpu, TAB[i].addr, TAB[i].data, rd);
            if (!TAB[i].wr) begin
                total++;
                if (rd !== TAB[i].exp) begin
                    bad++;
                    $display("FAIL R%0d row %0d actual=%h expected=%h",
                             TAB[i].req, i, rd, TAB[i].exp);
                end
            end
        end

        // R13 response timing
        acc(1'b0, 2'd0, 6'h12, 32'h0, rd);
        check("R13 read valid", 32'(rsp_valid), 32'h1);
        acc(1'b1, 2'd0, 6'h3F, 32'h0, rd);
        check("R13 write silent", 32'(rsp_valid), 32'h0);

        // R1 hold while halted
        acc(1'b0, 2'd0, 6'h01, 32'h0, a);
        repeat (10) @(negedge clk);
        acc(1'b0, 2'd0, 6'h01, 32'h0, b);
        check("R1 halted hold", b, a);

        // R2 step while running, R3 load ignored while running
        acc(1'b1, 2'd0, 6'h00, 32'h0, rd);
        acc(1'b0, 2'd0, 6'h01, 32'h0, a);
        acc(1'b0, 2'd1, 6'h01, 32'h0, b);
        check("R2 step by one", b - a, 32'h1);
        acc(1'b1, 2'd0, 6'h01, 32'h0, rd);
        acc(1'b1, 2'd0, 6'h00, 32'h1, rd);
        acc(1'b0, 2'd0, 6'h01, 32'h0, rd);
        check("R3 running load ignored", 32'(rd > b), 32'h1);

        // R6 / R7 compare match on cpu0 (mask 0x3F, route pin 3)
        acc(1'b1, 2'd0, 6'h01, 32'h200, rd);
        acc(1'b1, 2'd0, 6'h17, 32'h208, rd);
        check("R7 no pin before match", 32'(cpu_irq), 32'h0);
        acc(1'b0, 2'd0, 6'h11, 32'h0, rd);
        check("R6 no pending while halted", rd, 32'h0);
        acc(1'b1, 2'd0, 6'h00, 32'h0, rd);
        repeat (20) @(negedge clk);
        acc(1'b0, 2'd0, 6'h11, 32'h0, rd);
        check("R6 pending after match", rd, 32'h2);
        check("R7 pin 3 of cpu0", 32'(cpu_irq), 32'h8);
        acc(1'b1, 2'd0, 6'h14, 32'h2, rd);
        check("R7 masked pin low", 32'(cpu_irq), 32'h0);
        acc(1'b0, 2'd0, 6'h11, 32'h0, rd);
        check("R8 pending kept when masked", rd, 32'h2);
        acc(1'b1, 2'd0, 6'h13, 32'h2, rd);
        check("R8 unmask raises pin", 32'(cpu_irq), 32'h8);
        acc(1'b1, 2'd0, 6'h15, 32'h3, rd);
        check("R7 flag clear pin low", 32'(cpu_irq), 32'h0);
        acc(1'b1, 2'd0, 6'h15, 32'h80000005, rd);
        check("R7 rerouted to pin 5", 32'(cpu_irq), 32'h20);
        acc(1'b1, 2'd0, 6'h17, 32'hFFFFFFF0, rd);
        check("R5 compare write drops pin", 32'(cpu_irq), 32'h0);
        acc(1'b0, 2'd0, 6'h11, 32'h0, rd);
        check("R5 pending cleared", rd, 32'h0);
        acc(1'b0, 2'd0, 6'h17, 32'h0, rd);
        check("R5 compare stored", rd, 32'hFFFFFFF0);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule